// File: doc/BRIEF.md
# Cartridge Bank-Select Write Latch

This block sits on a cartridge's program-memory side of a 6502-style bus. It watches the CPU's A15 and A14 lines, the read/write line, the M2 phase clock and the 8-bit data bus. From these it forms the active-low ROM select as the NAND of A15 and M2. A CPU store anywhere in the upper 32 KB window writes a 4-bit bank number into a register. That register then drives the upper program-ROM address lines. The lower 16 KB of the window follows the stored bank. The upper 16 KB always points at the last bank.

The capture follows the bus timing. Address and read/write are settled from the rise of M2, but write data is only trustworthy at its fall. The register therefore loads at the moment ROM select returns high, which is the end of the M2 high phase. Read/write acts only as the load enable. The block runs on a fast system clock. ROM select and M2 pass through a two-stage synchroniser before edge detection. Data and read/write are sampled on the system-clock edge that sees ROM select go high.

Top module: `cart_bank_latch`

## Requirements
- R1: `rom_sel_n` is low exactly when `cpu_a15` and `cpu_m2` are both high, and it follows them with no clock delay.
- R2: A cycle with `cpu_a15`=1 and `cpu_rw`=0 loads `cpu_d[3:0]` into `bank`. The new value appears on the third rising `clk` edge after `rom_sel_n` rises.
- R3: The data loaded is the value present when M2 falls. A value driven earlier in the M2 high phase and then replaced is never loaded.
- R4: A read cycle (`cpu_rw`=1) with `cpu_a15`=1 leaves `bank` unchanged.
- R5: Any cycle with `cpu_a15`=0 leaves `bank` unchanged, whether it is a read or a write.
- R6: While `rst_n` is low, and after it is released, `bank` is 0. With `cpu_a14`=0, `prg_hi` is also 0.
- R7: Only `cpu_d[3:0]` is stored. `cpu_d[7:4]` has no effect on `bank`.
- R8: With `cpu_a14`=0, `prg_hi` equals `bank`. With `cpu_a14`=1, `prg_hi` is 4'b1111.
- R9: Writes load `bank` with either value of `cpu_a14`, that is, anywhere in the upper 32 KB window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_a15 | input | 1 | CPU address bit 15 |
| cpu_a14 | input | 1 | CPU address bit 14, picks the switchable or fixed half |
| cpu_rw | input | 1 | CPU read/write, 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU M2 phase clock |
| cpu_d | input | 8 | CPU data bus |
| rom_sel_n | output | 1 | Active-low ROM select, NAND of A15 and M2 |
| prg_hi | output | 4 | Program-ROM address bits 17 to 14 |
| bank | output | 4 | Currently stored bank number |

## Verification
The hardest case to reach from the ports is a write whose data is still moving while M2 is high. The correct value is visible only at the M2 fall, so a design that samples early or on a read/write edge would latch the stale byte. The bench drives such cycles. It changes the data part-way through the M2 high phase and holds the late value for several clocks after M2 falls. It then checks that only the late value is stored. These cycles are mixed with reads, writes with A15 low, and data with the upper nibble set, so the load enable and the nibble masking are each seen in isolation.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int DATA_W      = 8;
  localparam int BANK_W      = 4;
  localparam int SYNC_STAGES = 2;
  localparam int RST_STAGES  = 2;
  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/cbl_rst_sync.sv
// Reset conditioner: asserts at once, releases after STAGES clock edges.
module cbl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cbl_sync.sv
// Multi-bit, per-bit independent synchroniser with a per-bit reset value.
module cbl_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) stg_q <= {STAGES{RST_VAL[b]}};
      else         stg_q <= stg_d;
    end

    assign dout[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/cbl_bank_reg.sv
// Detects the end of ROM select and loads the bank on write cycles.
module cbl_bank_reg
  import cbl_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  logic  sel_n_s,   // synchronised ROM select
  input  logic  m2_s,      // synchronised M2
  input  logic  rw,        // raw read/write, sampled on the detect edge
  input  bank_t d_lo,      // raw data low bits, sampled on the detect edge
  output bank_t bank_q
);
  logic  sel_prev_q;
  logic  sel_rise;
  logic  load_en;
  bank_t bank_d;

  // Next-state: a rising select with M2 already low marks the end of an
  // M2-high phase inside the window; read/write gates the load.
  always_comb begin
    sel_rise = sel_n_s & ~sel_prev_q;
    load_en  = sel_rise & ~m2_s & ~rw;
    bank_d   = load_en ? d_lo : bank_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_prev_q <= 1'b1;
      bank_q     <= '0;
    end else begin
      sel_prev_q <= sel_n_s;
      if (load_en) bank_q <= bank_d;
    end
  end

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (sel_rise && !m2_s && !rw) |=> (bank_q == $past(d_lo)));

  assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!srst_n)
    sel_rise |=> !sel_rise);

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (sel_rise && rw) |=> $stable(bank_q));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !sel_rise |=> $stable(bank_q));
endmodule

// File: rtl/cbl_prg_map.sv
// Upper program address: switchable lower half, last bank in upper half.
module cbl_prg_map
  import cbl_pkg::*;
(
  input  logic  a14,
  input  bank_t bank,
  output bank_t prg_hi
);
  always_comb begin
    prg_hi = a14 ? {BANK_W{1'b1}} : bank;
  end
endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
  import cbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_a15,
  input  logic              cpu_a14,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic [DATA_W-1:0] cpu_d,
  output logic              rom_sel_n,
  output logic [BANK_W-1:0] prg_hi,
  output logic [BANK_W-1:0] bank
);
  logic       srst_n;
  logic [1:0] bus_raw;
  logic [1:0] bus_s;
  logic       unused_dhi;

  assign rom_sel_n  = ~(cpu_a15 & cpu_m2);
  assign bus_raw    = {cpu_m2, rom_sel_n};
  assign unused_dhi = ^cpu_d[DATA_W-1:BANK_W];

  cbl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // bit 1: M2 (idle low), bit 0: ROM select (idle high)
  cbl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk    (clk),
    .srst_n (srst_n),
    .din    (bus_raw),
    .dout   (bus_s)
  );

  cbl_bank_reg u_bank (
    .clk     (clk),
    .srst_n  (srst_n),
    .sel_n_s (bus_s[0]),
    .m2_s    (bus_s[1]),
    .rw      (cpu_rw),
    .d_lo    (cpu_d[BANK_W-1:0]),
    .bank_q  (bank)
  );

  cbl_prg_map u_map (
    .a14    (cpu_a14),
    .bank   (bank),
    .prg_hi (prg_hi)
  );

  assert_reset_clear_R6: assert property (@(posedge clk)
    $rose(srst_n) |-> (bank == '0));

  assert_fixed_half_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (cpu_a14 && bank != '1) |-> (prg_hi != bank));
endmodule

// File: tb/cart_bank_latch_bench.sv
module cart_bank_latch_bench;
  logic       clk;
  logic       rst_n;
  logic       cpu_a15, cpu_a14, cpu_rw, cpu_m2;
  logic [7:0] cpu_d;
  logic       rom_sel_n;
  logic [3:0] prg_hi, bank;

  int total;
  int bad;

  cart_bank_latch u_cart_bank_latch (
    .clk(clk), .rst_n(rst_n), .cpu_a15(cpu_a15), .cpu_a14(cpu_a14),
    .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .cpu_d(cpu_d),
    .rom_sel_n(rom_sel_n), .prg_hi(prg_hi), .bank(bank)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {a15, a14, rw, data_early[7:0], data_late[7:0], expected_bank[3:0]}
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 8'h05, 8'h05, 4'h5},  // R2 plain write
    {1'b1, 1'b1, 1'b0, 8'h0A, 8'h0A, 4'hA},  // R9 write in upper half
    {1'b1, 1'b0, 1'b1, 8'h03, 8'h03, 4'hA},  // R4 read keeps bank
    {1'b0, 1'b0, 1'b0, 8'h07, 8'h07, 4'hA},  // R5 write below window
    {1'b1, 1'b0, 1'b0, 8'h02, 8'h0C, 4'hC},  // R3 late data change
    {1'b1, 1'b0, 1'b0, 8'hF3, 8'hF3, 4'h3},  // R7 upper nibble dropped
    {1'b0, 1'b1, 1'b1, 8'h09, 8'h09, 4'h3},  // R5 read below window
    {1'b1, 1'b1, 1'b0, 8'h0F, 8'h96, 4'h6}   // R3 R7 late change, high nibble
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_cycle(input logic a15, input logic a14, input logic rw,
                           input logic [7:0] d_early, input logic [7:0] d_late);
    @(negedge clk);
    cpu_a15 = a15; cpu_a14 = a14; cpu_rw = rw; cpu_d = d_early; cpu_m2 = 1'b0;
    repeat (2) @(negedge clk);
    cpu_m2 = 1'b1;
    repeat (3) @(negedge clk);
    cpu_d = d_late;
    repeat (2) @(negedge clk);
    cpu_m2 = 1'b0;
    repeat (5) @(negedge clk);
    cpu_a15 = 1'b0; cpu_rw = 1'b1; cpu_d = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; cpu_a15 = 1'b0; cpu_a14 = 1'b0; cpu_rw = 1'b1;
    cpu_m2 = 1'b0; cpu_d = 8'h00;
    repeat (3) @(negedge clk);
    check("R6 bank in reset", {4'h0, bank}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 bank after release", {4'h0, bank}, 8'h00);
    check("R6 prg_hi low half", {4'h0, prg_hi}, 8'h00);

    // R1 select truth table, combinational
    for (int k = 0; k < 4; k++) begin
      cpu_a15 = k[1]; cpu_m2 = k[0];
      #1;
      check("R1 rom_sel_n", {7'h0, rom_sel_n}, {7'h0, ~(k[1] & k[0])});
    end
    cpu_a15 = 1'b0; cpu_m2 = 1'b0;

    // R2 latency: the third rising edge after select rises
    @(negedge clk);
    cpu_a15 = 1'b1; cpu_a14 = 1'b0; cpu_rw = 1'b0; cpu_d = 8'h0E; cpu_m2 = 1'b1;
    repeat (3) @(negedge clk);
    cpu_m2 = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 before third edge", {4'h0, bank}, 8'h00);
    @(negedge clk);
    check("R2 at third edge", {4'h0, bank}, 8'h0E);
    repeat (3) @(negedge clk);
    cpu_a15 = 1'b0; cpu_rw = 1'b1; cpu_d = 8'h00;
    repeat (2) @(negedge clk);

    // table walk
    for (int i = 0; i < 8; i++) begin
      bus_cycle(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12], VEC[i][11:4]);
      check("R2 R3 R4 R5 R7 R9 bank", {4'h0, bank}, {4'h0, VEC[i][3:0]});
      cpu_a14 = 1'b0; #1;
      check("R8 prg_hi lower half", {4'h0, prg_hi}, {4'h0, VEC[i][3:0]});
      cpu_a14 = 1'b1; #1;
      check("R8 prg_hi upper half", {4'h0, prg_hi}, 8'h0F);
    end

    // R6 reset in mid-run clears a stored bank
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 async clear", {4'h0, bank}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cpu_a14 = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 prg_hi after reset", {4'h0, prg_hi}, 8'h00);

    // R3 write right after reset, early value differs in low nibble
    bus_cycle(1'b1, 1'b0, 1'b0, 8'h01, 8'h0B);
    check("R3 late value after reset", {4'h0, bank}, 8'h0B);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule